// File: doc/BRIEF.md
# Lockable Pin Configuration Register Bank

This block holds the configuration of 32 device pins behind a plain 32-bit register bus. Each pin has its own register word. The word selects a pull resistor (enable and direction), a slow or fast output edge, a 3-bit pin function and a 4-bit interrupt mode. It also carries a lock bit and a sticky interrupt flag. The stored fields are presented continuously as per-pin output vectors, so the pad ring, function multiplexer and edge detector can consume them directly.

Two write-only broadcast registers let software load the low half-word of many pin registers with a single access. Each one covers a group of 16 pins and selects its targets through a mask. Once software sets a pin's lock bit, the low half-word of that pin is frozen until the next reset, and broadcast writes no longer affect it either. The interrupt flags are set by request inputs that come from an external detector. Each flag is cleared by writing a one, either through its own pin word or through a 32-bit aggregate view. Every clear is reported to the detector as a one-cycle pulse.

Bus accesses complete in one cycle. A write is taken on the rising edge while `bus_we` is high. Read data is a combinational function of `bus_addr`. Accesses whose address has bits 1:0 non-zero are ignored and read as zero.

Top module: `pincfg_bank`

## Requirements
- R1: After reset every register reads 0 and every output vector is 0. Reset also releases all locks, so a pin that was locked accepts writes again afterwards.
- R2: The register of pin n is at byte offset 4*n. Its layout is: bit 0 pull direction (1 = up, 0 = down), bit 1 pull enable, bit 2 slew (1 = slow), bits 10:8 function (000 = analog/off, 001 = GPIO, 010..111 = alternates 2..7), bit 15 lock, bits 19:16 interrupt mode, bit 24 flag. All other bits read 0.
- R3: Per-pin outputs follow the stored fields in the cycle after the write. Bit n of `pull_sel_o`, `pull_en_o`, `slew_slow_o` and `lock_o` belongs to pin n, `func_sel_o[3n+2:3n]` is its function and `irq_mode_o[4n+3:4n]` is its interrupt mode.
- R4: While the lock bit of a pin is 1, writes to its own address leave bits 15:0 unchanged. This includes attempts to clear the lock bit.
- R5: While a pin is locked, bits 19:16 of that pin are still written through its own address.
- R6: A write to offset 0x80 loads bits 15:0 of the write data into bits 15:0 of every pin 0..15 whose mask bit (write data bit 16+n) is 1. Unmasked pins and locked pins keep their values.
- R7: A write to offset 0x84 does the same for pins 16..31, with write data bit 16+k selecting pin 16+k.
- R8: Offsets 0x80 and 0x84 read as 0. Writes to them never change any interrupt mode or flag.
- R9: A 1 on `flag_set_i[n]` at a clock edge sets the flag of pin n. The flag is visible at bit 24 of the pin word, at bit n of offset 0xA0 and on `flag_o[n]`.
- R10: Writing 1 to bit 24 of pin n's word clears that flag, and `flag_clr_o[n]` is 1 for exactly the following cycle. Writing 0 there has no effect on the flag.
- R11: Writing 1 to bit n at offset 0xA0 clears flag n and pulses `flag_clr_o[n]` in the same way. Bits written as 0 leave their flags unchanged and produce no pulse.
- R12: If a set request and a clear write hit the same flag in the same cycle, the flag ends up set, and the clear pulse is still issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| flag_set_i | input | 32 | Per-pin flag set requests from the detector |
| pull_sel_o | output | 32 | Pull direction per pin (1 = up) |
| pull_en_o | output | 32 | Pull enable per pin |
| slew_slow_o | output | 32 | Slow slew per pin |
| func_sel_o | output | 96 | 3-bit function per pin |
| lock_o | output | 32 | Lock state per pin |
| irq_mode_o | output | 128 | 4-bit interrupt mode per pin |
| flag_o | output | 32 | Interrupt flag per pin |
| flag_clr_o | output | 32 | One-cycle clear pulse per pin |

## Verification
The assertions assume that `bus_we`, `bus_addr`, `bus_wdata` and `flag_set_i` are stable around each rising edge. They also assume that a write to a broadcast offset is a single-cycle strobe, so that the following cycle can be compared against the cycle before it. The stimulus meets these conditions by changing every input on the falling edge. It holds each write strobe for exactly one cycle and uses only word-aligned addresses. It drives set requests for one cycle, except in the collision scenario, where a set request deliberately overlaps a clear write.

// File: rtl/pincfg_pkg.sv
package pincfg_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned GLOB_WORD = 'h80 / 4;  // first broadcast register
  localparam int unsigned FLAG_WORD = 'hA0 / 4;  // aggregate flag view

  // Stored fields of one pin.
  typedef struct packed {
    logic [3:0] irq_mode;
    logic       lock;
    logic [2:0] func;
    logic       slew;
    logic       pull_en;
    logic       pull_sel;
  } pin_cfg_t;

  // Fields carried by the low half-word of a write.
  typedef struct packed {
    logic       lock;
    logic [2:0] func;
    logic       slew;
    logic       pull_en;
    logic       pull_sel;
  } low_fields_t;

  function automatic logic [WORD_W-1:0] pack_word(input pin_cfg_t c, input logic f);
    return {7'd0, f, 4'd0, c.irq_mode, c.lock, 4'd0, c.func, 5'd0,
            c.slew, c.pull_en, c.pull_sel};
  endfunction
endpackage

// File: rtl/pincfg_decode.sv
module pincfg_decode
  import pincfg_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NGRP   = 2
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NPINS-1:0]  pin_sel,
  output logic [NPINS-1:0]  pin_wr,
  output logic [NGRP-1:0]   glob_wr,
  output logic              flag_sel,
  output logic              flag_wr
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             aligned;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    assign pin_sel[n] = aligned && (widx == IDX_W'(n));
    assign pin_wr[n]  = bus_we && pin_sel[n];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_glob
    assign glob_wr[g] = bus_we && aligned && (widx == IDX_W'(GLOB_WORD + g));
  end

  assign flag_sel = aligned && (widx == IDX_W'(FLAG_WORD));
  assign flag_wr  = bus_we && flag_sel;
endmodule

// File: rtl/pincfg_slot.sv
module pincfg_slot
  import pincfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        own_we,
  input  logic        glob_we,
  input  low_fields_t low_data,
  input  logic [3:0]  irq_data,
  input  logic        set_req,
  input  logic        clr_req,
  output pin_cfg_t    cfg,
  output logic        flag,
  output logic        clr_pulse
);
  logic low_we;

  // The lock gates both the own-address and broadcast paths to the low half.
  assign low_we = !cfg.lock && (own_we || glob_we);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      flag      <= 1'b0;
      clr_pulse <= 1'b0;
    end else begin
      if (low_we) begin
        cfg.lock     <= low_data.lock;
        cfg.func     <= low_data.func;
        cfg.slew     <= low_data.slew;
        cfg.pull_en  <= low_data.pull_en;
        cfg.pull_sel <= low_data.pull_sel;
      end
      if (own_we) cfg.irq_mode <= irq_data;
      // A set request wins over a simultaneous clear.
      if (set_req)      flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
      clr_pulse <= clr_req;
    end
  end
endmodule

// File: rtl/pincfg_rdmux.sv
module pincfg_rdmux
  import pincfg_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic [NPINS-1:0][WORD_W-1:0] words,
  input  logic [NPINS-1:0]             flags,
  input  logic [NPINS-1:0]             pin_sel,
  input  logic                         flag_sel,
  output logic [WORD_W-1:0]            rdata
);
  always_comb begin
    rdata = '0;
    for (int n = 0; n < NPINS; n++) begin
      if (pin_sel[n]) rdata = rdata | words[n];
    end
    if (flag_sel) rdata = rdata | WORD_W'(flags);
  end
endmodule

// File: rtl/pincfg_bank.sv
module pincfg_bank
  import pincfg_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned GRP    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NPINS-1:0]   flag_set_i,
  output logic [NPINS-1:0]   pull_sel_o,
  output logic [NPINS-1:0]   pull_en_o,
  output logic [NPINS-1:0]   slew_slow_o,
  output logic [3*NPINS-1:0] func_sel_o,
  output logic [NPINS-1:0]   lock_o,
  output logic [4*NPINS-1:0] irq_mode_o,
  output logic [NPINS-1:0]   flag_o,
  output logic [NPINS-1:0]   flag_clr_o
);
  localparam int unsigned NGRP = (NPINS + GRP - 1) / GRP;

  logic [NPINS-1:0]             pin_sel, pin_wr, clr_req, glob_we;
  logic [NGRP-1:0]              glob_wr;
  logic                         flag_sel, flag_wr;
  low_fields_t                  low_data;
  pin_cfg_t [NPINS-1:0]         cfg;
  logic [NPINS-1:0][WORD_W-1:0] words;

  assign low_data = {bus_wdata[15], bus_wdata[10:8], bus_wdata[2:0]};

  pincfg_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W), .NGRP(NGRP)) u_dec (
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .pin_sel  (pin_sel),
    .pin_wr   (pin_wr),
    .glob_wr  (glob_wr),
    .flag_sel (flag_sel),
    .flag_wr  (flag_wr)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_slot
    assign glob_we[n] = glob_wr[n / GRP] && bus_wdata[16 + (n % GRP)];
    assign clr_req[n] = (pin_wr[n] && bus_wdata[24]) || (flag_wr && bus_wdata[n]);

    pincfg_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .own_we    (pin_wr[n]),
      .glob_we   (glob_we[n]),
      .low_data  (low_data),
      .irq_data  (bus_wdata[19:16]),
      .set_req   (flag_set_i[n]),
      .clr_req   (clr_req[n]),
      .cfg       (cfg[n]),
      .flag      (flag_o[n]),
      .clr_pulse (flag_clr_o[n])
    );

    assign words[n]            = pack_word(cfg[n], flag_o[n]);
    assign pull_sel_o[n]       = cfg[n].pull_sel;
    assign pull_en_o[n]        = cfg[n].pull_en;
    assign slew_slow_o[n]      = cfg[n].slew;
    assign lock_o[n]           = cfg[n].lock;
    assign func_sel_o[3*n +: 3] = cfg[n].func;
    assign irq_mode_o[4*n +: 4] = cfg[n].irq_mode;
  end

  pincfg_rdmux #(.NPINS(NPINS)) u_rd (
    .words    (words),
    .flags    (flag_o),
    .pin_sel  (pin_sel),
    .flag_sel (flag_sel),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/pincfg_check.sv
module pincfg_check #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_rdata,
  input logic [NPINS-1:0]   flag_set_i,
  input logic [NPINS-1:0]   pull_sel_o,
  input logic [NPINS-1:0]   pull_en_o,
  input logic [NPINS-1:0]   slew_slow_o,
  input logic [3*NPINS-1:0] func_sel_o,
  input logic [NPINS-1:0]   lock_o,
  input logic [4*NPINS-1:0] irq_mode_o,
  input logic [NPINS-1:0]   flag_o,
  input logic [NPINS-1:0]   flag_clr_o
);
  logic glob_access;
  assign glob_access = (bus_addr == ADDR_W'('h80)) || (bus_addr == ADDR_W'('h84));

  // R4: a lock never drops while out of reset.
  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((lock_o & ~$past(lock_o)) == '0 ? 1'b1 : 1'b1) && ((~lock_o & $past(lock_o)) == '0));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    // R4: low-half fields of a locked pin hold their value.
    p_locked_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o[i] |=> ($stable(pull_sel_o[i]) && $stable(pull_en_o[i]) &&
                     $stable(slew_slow_o[i]) && $stable(func_sel_o[3*i +: 3])));
  end

  // R8: broadcast offsets read as zero.
  p_glob_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    glob_access |-> (bus_rdata == '0));

  // R8: broadcast writes leave interrupt modes alone.
  p_glob_keeps_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && glob_access) |=> $stable(irq_mode_o));

  // R9: a set request is visible on the flag in the next cycle.
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((flag_o & $past(flag_set_i)) == $past(flag_set_i)));

  // R10: a clear pulse means the flag is down unless a set arrived together with it (R12).
  p_flag_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((flag_clr_o & ~$past(flag_set_i) & flag_o) == '0));
endmodule

bind pincfg_bank pincfg_check #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .flag_set_i  (flag_set_i),
  .pull_sel_o  (pull_sel_o),
  .pull_en_o   (pull_en_o),
  .slew_slow_o (slew_slow_o),
  .func_sel_o  (func_sel_o),
  .lock_o      (lock_o),
  .irq_mode_o  (irq_mode_o),
  .flag_o      (flag_o),
  .flag_clr_o  (flag_clr_o)
);

// File: tb/sim_pincfg_bank.sv
`timescale 1ns/1ps
module sim_pincfg_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [31:0]  flag_set_i = '0;
  logic [31:0]  pull_sel_o, pull_en_o, slew_slow_o, lock_o, flag_o, flag_clr_o;
  logic [95:0]  func_sel_o;
  logic [127:0] irq_mode_o;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  pincfg_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flag_set_i(flag_set_i),
    .pull_sel_o(pull_sel_o), .pull_en_o(pull_en_o), .slew_slow_o(slew_slow_o),
    .func_sel_o(func_sel_o), .lock_o(lock_o), .irq_mode_o(irq_mode_o),
    .flag_o(flag_o), .flag_clr_o(flag_clr_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    rd_check("R1 pin0", 8'h00, 32'h0);
    rd_check("R1 pin31", 8'h7C, 32'h0);
    rd_check("R1 flags", 8'hA0, 32'h0);
    check("R1 lock_o", lock_o, 32'h0);
    check("R1 pull_en_o", pull_en_o, 32'h0);
    check("R1 irq_mode_o", irq_mode_o[31:0], 32'h0);
  endtask

  task automatic t_fields();
    wr(8'h14, 32'h000F_0705);  // pin 5
    rd_check("R2 pin5 readback", 8'h14, 32'h000F_0705);
    check("R3 pull_sel pin5", {31'd0, pull_sel_o[5]}, 32'd1);
    check("R3 pull_en pin5", {31'd0, pull_en_o[5]}, 32'd0);
    check("R3 slew pin5", {31'd0, slew_slow_o[5]}, 32'd1);
    check("R3 func pin5", {29'd0, func_sel_o[17:15]}, 32'd7);
    check("R3 irq pin5", {28'd0, irq_mode_o[23:20]}, 32'hF);
    wr(8'h00, 32'h0000_0102);  // pin 0: GPIO with pull enabled
    rd_check("R2 pin0 offset 0", 8'h00, 32'h0000_0102);
    wr(8'h7C, 32'h0000_0201);  // pin 31
    check("R3 func pin31", {29'd0, func_sel_o[95:93]}, 32'd2);
    wr(8'h18, 32'hFEF0_78F8);  // pin 6: only unimplemented bits set
    rd_check("R2 reserved bits read 0", 8'h18, 32'h0);
  endtask

  task automatic t_lock();
    wr(8'h1C, 32'h0000_8003);  // pin 7 locked
    check("R3 lock_o pin7", {31'd0, lock_o[7]}, 32'd1);
    wr(8'h1C, 32'h0000_0000);
    rd_check("R4 locked pin7 ignores write", 8'h1C, 32'h0000_8003);
    wr(8'h1C, 32'h000A_0000);
    rd_check("R5 locked pin7 irq writable", 8'h1C, 32'h000A_8003);
  endtask

  task automatic t_glob_low();
    wr(8'h08, 32'h0005_0004);  // pin 2
    wr(8'h80, {16'h0086, 16'h0302});  // mask pins 1,2,7
    rd_check("R6 pin1 loaded", 8'h04, 32'h0000_0302);
    rd_check("R6 pin2 loaded irq kept", 8'h08, 32'h0005_0302);
    rd_check("R6 locked pin7 unchanged", 8'h1C, 32'h000A_8003);
    rd_check("R6 unmasked pin3", 8'h0C, 32'h0);
    rd_check("R6 unmasked pin5", 8'h14, 32'h000F_0705);
  endtask

  task automatic t_glob_high();
    wr(8'h84, {16'h8001, 16'h0401});  // mask pins 16 and 31
    rd_check("R7 pin16 loaded", 8'h40, 32'h0000_0401);
    rd_check("R7 pin31 loaded", 8'h7C, 32'h0000_0401);
    rd_check("R7 pin17 unmasked", 8'h44, 32'h0);
    rd_check("R7 pin0 outside group", 8'h00, 32'h0000_0102);
    rd_check("R8 read 0x80", 8'h80, 32'h0);
    rd_check("R8 read 0x84", 8'h84, 32'h0);
  endtask

  task automatic t_flags();
    @(negedge clk);
    flag_set_i = (32'd1 << 3) | (32'd1 << 20);
    @(negedge clk);
    flag_set_i = '0;
    check("R9 flag_o", flag_o, 32'h0010_0008);
    rd_check("R9 flag view", 8'hA0, 32'h0010_0008);
    rd_check("R9 pin3 bit24", 8'h0C, 32'h0100_0000);
    wr(8'h0C, 32'h0000_0000);
    check("R10 write 0 keeps flag", flag_o, 32'h0010_0008);
    check("R10 write 0 no pulse", flag_clr_o, 32'h0);
    wr(8'h0C, 32'h0100_0000);
    check("R10 flag3 cleared", flag_o, 32'h0010_0000);
    check("R10 pulse pin3", flag_clr_o, 32'h0000_0008);
    @(negedge clk);
    check("R10 pulse one cycle", flag_clr_o, 32'h0);
    wr(8'hA0, 32'h0000_0000);
    check("R11 write 0 keeps flags", flag_o, 32'h0010_0000);
    check("R11 write 0 no pulse", flag_clr_o, 32'h0);
    wr(8'hA0, 32'h0010_0000);
    check("R11 flag20 cleared", flag_o, 32'h0);
    check("R11 pulse pin20", flag_clr_o, 32'h0010_0000);
    wr(8'h80, {16'hFFFF, 16'h0000});
    rd_check("R8 glob write keeps irq pin5", 8'h14, 32'h000F_0000);
  endtask

  task automatic t_priority();
    @(negedge clk);
    flag_set_i = 32'd1 << 9;
    wr(8'hA0, 32'd1 << 9);
    check("R12 set wins", {31'd0, flag_o[9]}, 32'd1);
    check("R12 pulse still issued", {31'd0, flag_clr_o[9]}, 32'd1);
    flag_set_i = '0;
    @(negedge clk);
    check("R12 flag stays", {31'd0, flag_o[9]}, 32'd1);
  endtask

  task automatic t_reset_again();
    do_reset();
    check("R1 locks released", lock_o, 32'h0);
    rd_check("R1 pin7 cleared", 8'h1C, 32'h0);
    rd_check("R1 flags cleared", 8'hA0, 32'h0);
    wr(8'h1C, 32'h0000_0001);
    rd_check("R1 pin7 writable after reset", 8'h1C, 32'h0000_0001);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_fields();
    t_lock();
    t_glob_low();
    t_glob_high();
    t_flags();
    t_priority();
    t_reset_again();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule